// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores incoming frames in memory buffers that are tracked by a ring of receive descriptors. Each descriptor is a status word and a length word held inside the block. Software arms a descriptor by setting its empty bit. The engine then fills that descriptor's buffer byte by byte through a write port. When the frame's last byte arrives, the engine writes the frame length and the final status, which hands the descriptor back to software. Every buffer has a fixed size of `BUF_BYTES`. The buffer of descriptor `i` starts at byte address `i*BUF_BYTES`.

The engine checks ownership only at the start of a frame. If the current descriptor is not empty, the engine raises a busy event, halts, and drops the frame. Reception stays halted until software clears the busy event and then issues a clear-halt command. A graceful stop request lets the frame in progress finish, then stops the engine and raises a stop-complete event. Frames that arrive while the engine is halted or stopped are dropped whole. Error indications come in with the last byte and are copied into the status word unchanged.

Register map (`reg_addr`):
- 0: events. Bit 0 is busy and bit 1 is stop-complete. Writing 1 to a bit clears it.
- 1: command on write, with bit 0 = clear halt and bit 1 = graceful stop request. On read it returns state: bit 0 halted, bit 1 stopped, bit 2 stop pending.
- 2: descriptor select.
- 3: status of the selected descriptor (read/write).
- 4: length of the selected descriptor (read/write).

Status word layout:
- Bit 15: empty.
- Bit 13: wrap.
- Bit 11: last.
- Bits 7:0: errors.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, the event register reads 0, the state register reads 0, every descriptor status reads 0, and `mem_we` is low.
- R2: Byte k of an accepted frame that uses descriptor i is written to address `i*BUF_BYTES+k`. `mem_we` rises one cycle after the byte is sampled.
- R3: On the last byte, the descriptor status gets empty (bit 15) = 0 and last (bit 11) = 1, and its wrap bit (13) is kept. The length gets the full byte count, including the 4-byte FCS.
- R4: Status bits 7:0 take `in_err` as sampled with the last byte. A clean frame leaves them 0.
- R5: After a descriptor whose wrap bit is set, or after index `NUM_DESC-1`, the next frame uses descriptor 0.
- R6: If the current descriptor is not empty when a frame starts, event bit 0 sets, the halted flag sets, and the frame is dropped with no write and no descriptor change.
- R7: While halted, frames are dropped whole. A clear-halt command has no effect while event bit 0 is set. After event bit 0 is cleared, clear-halt resumes reception at the same descriptor.
- R8: A stop request received mid-frame lets that frame complete. The engine then sets stopped and event bit 1, accepts no new frames, and resumes on clear-halt.
- R9: Bytes beyond `BUF_BYTES` are not written, but they are still counted in the length.
- R10: Writing a 1 to an event bit clears it. Writing a 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A frame byte is present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 8 | Error flags, valid with the final byte |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | IDX_W+OFF_W | Buffer byte address |
| mem_data | output | 8 | Buffer write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |

## Verification
The bench drives the ring through a full wrap. It then re-arms descriptor 0 and confirms that the next frame lands at address 0. A design that ignored the wrap bit would write past the ring instead.

It provokes the busy halt and then arms the stalled descriptor before clearing the event. This exposes a design that resumes on its own, or that accepts clear-halt while busy is still set. A design with either fault would write the dropped frame.

A 70-byte frame checks that the write count stops at the buffer size while the length still counts all 70 bytes. A stop request issued mid-frame must still let that frame complete, which catches a design that cuts frames short.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int NUM_DESC  = 8,
  parameter int BUF_BYTES = 64,
  localparam int IDX_W = $clog2(NUM_DESC),
  localparam int OFF_W = $clog2(BUF_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  input  logic                   in_last,
  input  logic [7:0]             in_err,
  output logic                   mem_we,
  output logic [IDX_W+OFF_W-1:0] mem_addr,
  output logic [7:0]             mem_data,
  input  logic                   reg_we,
  input  logic [2:0]             reg_addr,
  input  logic [15:0]            reg_wdata,
  output logic [15:0]            reg_rdata
);

  localparam int B_EMPTY = 15;
  localparam int B_WRAP  = 13;

  logic [15:0]      stat_q [NUM_DESC];
  logic [15:0]      len_q  [NUM_DESC];
  logic [IDX_W-1:0] cur_q, sel_q;
  logic [15:0]      cnt_q;
  logic in_frame_q, drop_q, halted_q, stopped_q, stop_pend_q, ev_busy_q, ev_stop_q;

  wire sof       = in_valid && !in_frame_q;
  wire start_ok  = !halted_q && !stopped_q && !stop_pend_q;
  wire cur_empty = stat_q[cur_q][B_EMPTY];
  wire busy_hit  = sof && start_ok && !cur_empty;
  wire keep      = in_valid && (sof ? (start_ok && cur_empty) : !drop_q);
  wire fin       = keep && in_last;
  wire [15:0] offset = sof ? 16'd0 : cnt_q;
  wire wr_cmd    = reg_we && (reg_addr == 3'd1);
  wire clr_halt  = wr_cmd && reg_wdata[0];
  wire stop_req  = wr_cmd && reg_wdata[1];
  wire stop_done = stop_pend_q && !in_frame_q;
  wire last_slot = stat_q[cur_q][B_WRAP] || (cur_q == IDX_W'(NUM_DESC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        stat_q[i] <= '0;
        len_q[i]  <= '0;
      end
      cur_q       <= '0;
      sel_q       <= '0;
      cnt_q       <= '0;
      in_frame_q  <= 1'b0;
      drop_q      <= 1'b0;
      halted_q    <= 1'b0;
      stopped_q   <= 1'b0;
      stop_pend_q <= 1'b0;
      ev_busy_q   <= 1'b0;
      ev_stop_q   <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_data    <= '0;
    end else begin
      mem_we   <= keep && (offset < 16'(BUF_BYTES));
      mem_addr <= {cur_q, offset[OFF_W-1:0]};
      mem_data <= in_data;
      if (in_valid) in_frame_q <= !in_last;
      if (sof) drop_q <= !(start_ok && cur_empty);
      if (keep) cnt_q <= 16'(offset + 16'd1);

      if (reg_we) begin
        case (reg_addr)
          3'd0: begin
            ev_busy_q <= ev_busy_q & ~reg_wdata[0];
            ev_stop_q <= ev_stop_q & ~reg_wdata[1];
          end
          3'd2: sel_q <= reg_wdata[IDX_W-1:0];
          3'd3: stat_q[sel_q] <= reg_wdata;
          3'd4: len_q[sel_q] <= reg_wdata;
          default: ;
        endcase
      end

      if (clr_halt && !ev_busy_q) begin
        halted_q  <= 1'b0;
        stopped_q <= 1'b0;
      end
      if (stop_req) stop_pend_q <= 1'b1;
      if (stop_done) begin
        stop_pend_q <= 1'b0;
        stopped_q   <= 1'b1;
        ev_stop_q   <= 1'b1;
      end
      if (busy_hit) begin
        ev_busy_q <= 1'b1;
        halted_q  <= 1'b1;
      end

      if (fin) begin
        stat_q[cur_q] <= {2'b00, stat_q[cur_q][B_WRAP], 1'b0, 1'b1, 3'b000, in_err};
        len_q[cur_q]  <= 16'(offset + 16'd1);
        cur_q         <= last_slot ? '0 : cur_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {14'd0, ev_stop_q, ev_busy_q};
      3'd1:    reg_rdata = {13'd0, stop_pend_q, stopped_q, halted_q};
      3'd2:    reg_rdata = 16'(sel_q);
      3'd3:    reg_rdata = stat_q[sel_q];
      3'd4:    reg_rdata = len_q[sel_q];
      default: reg_rdata = 16'd0;
    endcase
  end

  assert_write_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(in_valid));

  assert_no_write_when_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(halted_q));

  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !clr_halt) |=> halted_q);

  assert_busy_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_busy_q) |-> halted_q);

  assert_stop_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_stop_q) |-> (stopped_q && !$past(in_frame_q)));

  assert_no_write_when_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(stopped_q)) |-> 1'b0);

endmodule

// File: tb/rx_ring_engine_tb_top.sv
module rx_ring_engine_tb_top;
  localparam int ND = 8;
  localparam int BB = 64;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0, in_err = 0;
  logic mem_we;
  logic [8:0] mem_addr;
  logic [7:0] mem_data;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;

  int checks = 0, errors = 0, wr_cnt = 0;
  logic [7:0] cap [ND*BB];

  always #2 clk = ~clk;

  rx_ring_engine #(.NUM_DESC(ND), .BUF_BYTES(BB)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_err(in_err), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always @(negedge clk) if (mem_we) begin
    cap[mem_addr] = mem_data;
    wr_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic arm(input int i, input logic wrap);
    reg_wr(3'd2, 16'(i));
    reg_wr(3'd3, {2'b10, wrap, 13'd0});
  endtask

  task automatic desc(input int i, output logic [15:0] s, output logic [15:0] l);
    reg_wr(3'd2, 16'(i));
    reg_rd(3'd3, s);
    reg_rd(3'd4, l);
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed, input logic [7:0] err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = seed + 8'(i); in_last = (i == n - 1);
      in_err = (i == n - 1) ? err : 8'd0;
    end
    @(negedge clk); in_valid = 0; in_last = 0; in_err = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v, l;
    chk("R1 mem_we", 32'(mem_we), 0);
    reg_rd(3'd0, v); chk("R1 events", 32'(v), 0);
    reg_rd(3'd1, v); chk("R1 state", 32'(v), 0);
    desc(0, v, l); chk("R1 desc0 status", 32'(v), 0);
  endtask

  task automatic t_fill;
    logic [15:0] s, l; int w0;
    arm(0, 0); arm(1, 0); arm(2, 0); arm(3, 1);
    w0 = wr_cnt; send_frame(10, 8'h10, 8'h00);
    chk("R2 write count", 32'(wr_cnt - w0), 10);
    chk("R2 first byte", 32'(cap[0]), 32'h10);
    chk("R2 last byte", 32'(cap[9]), 32'h19);
    desc(0, s, l);
    chk("R3 status clean", 32'(s), 32'h0800);
    chk("R3 length", 32'(l), 10);
    send_frame(5, 8'h40, 8'h25);
    desc(1, s, l);
    chk("R4 error bits", 32'(s), 32'h0825);
    chk("R2 desc1 base", 32'(cap[64]), 32'h40);
    send_frame(3, 8'h60, 8'h00);
    send_frame(4, 8'h70, 8'h00);
    desc(3, s, l);
    chk("R3 wrap kept", 32'(s), 32'h2800);
    chk("R3 length desc3", 32'(l), 4);
  endtask

  task automatic t_wrap;
    logic [15:0] s, l;
    arm(0, 0);
    send_frame(2, 8'h90, 8'h00);
    chk("R5 back at base", 32'(cap[0]), 32'h90);
    desc(0, s, l);
    chk("R5 desc0 length", 32'(l), 2);
  endtask

  task automatic t_busy;
    logic [15:0] v, l; int w0;
    w0 = wr_cnt; send_frame(6, 8'hA0, 8'h00);
    chk("R6 no writes", 32'(wr_cnt - w0), 0);
    reg_rd(3'd0, v); chk("R6 busy event", 32'(v), 1);
    reg_rd(3'd1, v); chk("R6 halted", 32'(v), 1);
    desc(1, v, l); chk("R6 desc untouched", 32'(v), 32'h0825);
  endtask

  task automatic t_resume;
    logic [15:0] v, l; int w0;
    arm(1, 0);
    w0 = wr_cnt; send_frame(4, 8'hE0, 8'h00);
    chk("R7 dropped while halted", 32'(wr_cnt - w0), 0);
    desc(1, v, l); chk("R7 desc still armed", 32'(v), 32'h8000);
    reg_wr(3'd1, 16'h0001);
    reg_rd(3'd1, v); chk("R7 clear ignored while busy", 32'(v), 1);
    reg_wr(3'd0, 16'h0000);
    reg_rd(3'd0, v); chk("R10 zero write keeps", 32'(v), 1);
    reg_wr(3'd0, 16'h0001);
    reg_rd(3'd0, v); chk("R10 one write clears", 32'(v), 0);
    reg_wr(3'd1, 16'h0001);
    reg_rd(3'd1, v); chk("R7 running again", 32'(v), 0);
    send_frame(3, 8'hB0, 8'h00);
    chk("R7 resumed at desc1", 32'(cap[64]), 32'hB0);
    desc(1, v, l); chk("R7 desc1 length", 32'(l), 3);
  endtask

  task automatic t_overflow;
    logic [15:0] s, l; int w0;
    arm(2, 0);
    w0 = wr_cnt; send_frame(70, 8'h00, 8'h00);
    chk("R9 writes capped", 32'(wr_cnt - w0), 64);
    chk("R9 last stored byte", 32'(cap[191]), 32'h3F);
    desc(2, s, l);
    chk("R9 full length", 32'(l), 70);
  endtask

  task automatic t_stop;
    logic [15:0] v, l; int w0;
    arm(3, 1);
    w0 = wr_cnt;
    fork
      send_frame(8, 8'hC0, 8'h00);
      begin repeat (3) @(negedge clk); reg_wr(3'd1, 16'h0002); end
    join
    chk("R8 frame completes", 32'(wr_cnt - w0), 8);
    desc(3, v, l);
    chk("R8 desc3 status", 32'(v), 32'h2800);
    chk("R8 desc3 length", 32'(l), 8);
    reg_rd(3'd0, v); chk("R8 stop event", 32'(v), 2);
    reg_rd(3'd1, v); chk("R8 stopped", 32'(v), 2);
    arm(0, 0);
    w0 = wr_cnt; send_frame(3, 8'hF0, 8'h00);
    chk("R8 no frame while stopped", 32'(wr_cnt - w0), 0);
    reg_wr(3'd0, 16'h0002);
    reg_rd(3'd0, v); chk("R10 stop event cleared", 32'(v), 0);
    reg_wr(3'd1, 16'h0001);
    send_frame(2, 8'hD0, 8'h00);
    chk("R8 resumed", 32'(cap[0]), 32'hD0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_wrap;
    t_busy;
    t_resume;
    t_overflow;
    t_stop;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule